// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns 32-bit virtual addresses into physical addresses. Each address is cut into three fields: the top ten bits index an outer table, the next ten bits index an inner table, and the low twelve bits are the byte offset inside a 4 KiB page. Both tables live in memory. On a miss the block first reads the outer entry, which names the inner table. It then reads the inner entry, which names the physical frame. The physical address is that frame with the untouched offset appended.

A four-entry, fully associative translation cache holds recent page-number-to-frame pairs. On a hit the answer comes back with no memory read at all. Software loads a root register with the frame number of the outer table when it switches processes. That write empties the cache. Only one translation is in flight at a time. A request is taken with a valid/ready handshake and answered by a one-cycle response pulse that carries either a physical address or a page-fault flag.

Top module: `pt_walker`

## Requirements
- R1: The first memory read of a walk is at address root_frame*4096 + vaddr[31:22]*4, where root_frame is the root register value in force when the request is accepted. A root write in the same cycle as acceptance counts as in force.
- R2: If the outer entry is valid, the second read is at address outer_entry[31:12]*4096 + vaddr[21:12]*4.
- R3: A successful translation returns rsp_paddr = inner_entry[31:12]*4096 + vaddr[11:0] with rsp_fault = 0.
- R4: Bit 0 of a table entry is its valid bit. If the outer entry has bit 0 = 0, the walk ends after one read. If the inner entry has bit 0 = 0, it ends after two reads. Either way the response carries rsp_fault = 1 and rsp_paddr = 0.
- R5: A translation-cache hit gives rsp_valid in the cycle after acceptance, with the correct address and no memory read.
- R6: Every successful walk stores its page-number/frame pair in the cache. The cache has 4 entries, and fills use a round-robin pointer, so the fifth distinct fill replaces the first.
- R7: A root write invalidates every cache entry, so the next translation of any page walks again. The round-robin pointer is left where it was.
- R8: req_ready is low while a walk is in progress, and rsp_valid is high for exactly one cycle per accepted request.
- R9: mem_req stays high with a stable mem_addr until mem_ack is seen, for any number of wait cycles.
- R10: Faulting translations are never stored in the cache.
- R11: If the root register is written while a walk is in progress, the result of that walk is still returned but is not stored in the cache.
- R12: After reset, req_ready = 1, rsp_valid = 0, mem_req = 0, and the cache holds no valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_we | input | 1 | Load the root register and empty the cache |
| root_frame | input | 20 | Frame number of the outer table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| mem_req | output | 1 | Table-entry read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ack | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 32 | Table entry returned by memory |

## Verification
A cache hit is answered one cycle after the accepting edge. A walk raises its first read request one cycle after acceptance, raises the second read one cycle after the first acknowledge, and answers one cycle after the last acknowledge. Each wait cycle the memory inserts moves all later events by exactly one cycle. The bench drives every input on the falling edge and samples on the falling edge that follows the edge in question. It checks each read address at the moment it acknowledges, counts the reads of every translation against the count its own cache model predicts, and looks one falling edge after each response to confirm the pulse has dropped.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int VA_W      = 32;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 10;
  localparam int VPN_W     = VA_W - OFF_W;
  localparam int PFN_W     = VA_W - OFF_W;
  localparam int PTE_W     = 32;
  localparam int PTE_SHIFT = 2;   // entry size is 4 bytes

  typedef logic [VA_W-1:0]  addr_t;
  typedef logic [VPN_W-1:0] vpn_t;
  typedef logic [PFN_W-1:0] pfn_t;
  typedef logic [PTE_W-1:0] pte_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [OFF_W-1:0] off_t;

  function automatic idx_t outer_idx(addr_t va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic idx_t inner_idx(addr_t va);
    return va[OFF_W+IDX_W-1 -: IDX_W];
  endfunction

  function automatic off_t page_off(addr_t va);
    return va[OFF_W-1:0];
  endfunction

  function automatic vpn_t vpn_of(addr_t va);
    return va[VA_W-1:OFF_W];
  endfunction

  // base of table + index scaled by entry size
  function automatic addr_t entry_addr(pfn_t base, idx_t idx);
    addr_t a;
    a = {base, {OFF_W{1'b0}}};
    return a + (addr_t'(idx) << PTE_SHIFT);
  endfunction

  function automatic addr_t phys_addr(pfn_t pfn, off_t off);
    return {pfn, off};
  endfunction

  function automatic logic pte_ok(pte_t pte);
    return pte[0];
  endfunction

  function automatic pfn_t pte_pfn(pte_t pte);
    return pte[PTE_W-1 -: PFN_W];
  endfunction
endpackage

// File: rtl/pt_tlb.sv
module pt_tlb
  import pt_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  vpn_t               look_vpn,
  output logic               hit,
  output pfn_t               hit_pfn,
  input  logic               flush,
  input  logic               fill_en,
  input  vpn_t               fill_vpn,
  input  pfn_t               fill_pfn,
  output logic [ENTRIES-1:0] valid_vec
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  vpn_t               vpn_q [ENTRIES];
  pfn_t               pfn_q [ENTRIES];
  logic [ENTRIES-1:0] val_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = val_q[i] && (vpn_q[i] == look_vpn);
  end

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_pfn = hit_pfn | pfn_q[i];
  end

  assign hit       = |match;
  assign valid_vec = val_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q[i] <= 1'b0;
        vpn_q[i] <= '0;
        pfn_q[i] <= '0;
      end else if (flush) begin
        val_q[i] <= 1'b0;
      end else if (fill_en && (ptr_q == PTR_W'(i))) begin
        val_q[i] <= 1'b1;
        vpn_q[i] <= fill_vpn;
        pfn_q[i] <= fill_pfn;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (fill_en && !flush)
      ptr_q <= (ptr_q == PTR_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  addr_t va_in,
  input  pfn_t  root_in,
  input  logic  root_we,
  output logic  busy,
  output logic  mem_req,
  output addr_t mem_addr,
  input  logic  mem_ack,
  input  pte_t  mem_rdata,
  output logic  done,
  output logic  fault,
  output pfn_t  walk_pfn,
  output addr_t walk_va,
  output logic  fill_ok
);
  typedef enum logic [1:0] {W_IDLE, W_OUTER, W_INNER} wst_e;

  wst_e  st_q;
  addr_t va_q;
  pfn_t  base_q;
  logic  stale_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      case (st_q)
        W_IDLE: if (start) begin
          va_q    <= va_in;
          base_q  <= root_in;
          stale_q <= 1'b0;
          st_q    <= W_OUTER;
        end
        W_OUTER: begin
          if (root_we) stale_q <= 1'b1;
          if (mem_ack) begin
            if (pte_ok(mem_rdata)) begin
              base_q <= pte_pfn(mem_rdata);
              st_q   <= W_INNER;
            end else begin
              st_q   <= W_IDLE;
            end
          end
        end
        W_INNER: begin
          if (root_we) stale_q <= 1'b1;
          if (mem_ack) st_q <= W_IDLE;
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != W_IDLE);
  assign mem_req  = busy;
  assign mem_addr = entry_addr(base_q,
                               (st_q == W_OUTER) ? outer_idx(va_q) : inner_idx(va_q));
  assign fault    = !pte_ok(mem_rdata);
  assign done     = mem_ack && ((st_q == W_INNER) || ((st_q == W_OUTER) && fault));
  assign walk_pfn = pte_pfn(mem_rdata);
  assign walk_va  = va_q;
  assign fill_ok  = done && !fault && !stale_q && !root_we;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int TLB_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        root_we,
  input  logic [19:0] root_frame,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_paddr,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  pfn_t root_q;
  pfn_t root_eff;
  logic busy;
  logic accept;
  logic tlb_hit;
  pfn_t tlb_pfn;
  logic [TLB_ENTRIES-1:0] tlb_valid;

  // named events for the checker
  logic  hit_ev;
  logic  walk_start;
  logic  walk_done;
  logic  walk_fault;
  pfn_t  walk_pfn;
  addr_t walk_va;
  logic  fill_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       root_q <= '0;
    else if (root_we) root_q <= root_frame;
  end

  assign root_eff   = root_we ? root_frame : root_q;
  assign req_ready  = !busy;
  assign accept     = req_valid && req_ready;
  assign hit_ev     = accept && tlb_hit && !root_we;
  assign walk_start = accept && !hit_ev;

  pt_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_vpn  (vpn_of(req_vaddr)),
    .hit       (tlb_hit),
    .hit_pfn   (tlb_pfn),
    .flush     (root_we),
    .fill_en   (fill_ok),
    .fill_vpn  (vpn_of(walk_va)),
    .fill_pfn  (walk_pfn),
    .valid_vec (tlb_valid)
  );

  pt_walk_ctrl u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (walk_start),
    .va_in     (req_vaddr),
    .root_in   (root_eff),
    .root_we   (root_we),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .done      (walk_done),
    .fault     (walk_fault),
    .walk_pfn  (walk_pfn),
    .walk_va   (walk_va),
    .fill_ok   (fill_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= hit_ev || walk_done;
      rsp_fault <= walk_done && walk_fault;
      if (hit_ev)
        rsp_paddr <= phys_addr(tlb_pfn, page_off(req_vaddr));
      else if (walk_done && !walk_fault)
        rsp_paddr <= phys_addr(walk_pfn, page_off(walk_va));
      else
        rsp_paddr <= '0;
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int TLB_ENTRIES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   root_we,
  input logic                   req_ready,
  input logic                   rsp_valid,
  input logic                   rsp_fault,
  input logic [31:0]            rsp_paddr,
  input logic                   mem_req,
  input logic [31:0]            mem_addr,
  input logic                   mem_ack,
  input logic                   hit_ev,
  input logic                   walk_start,
  input logic [TLB_ENTRIES-1:0] tlb_valid
);
  a_r9_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r8_no_accept_while_walking: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  a_r8_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(hit_ev || (mem_req && mem_ack)));

  a_r5_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> rsp_valid && !rsp_fault && !mem_req);

  a_r4_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == 32'd0);

  a_r7_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    root_we |=> tlb_valid == '0);

  a_r1_walk_reads: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> mem_req);
endmodule

bind pt_walker pt_walker_chk #(.TLB_ENTRIES(TLB_ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .root_we    (root_we),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .hit_ev     (hit_ev),
  .walk_start (walk_start),
  .tlb_valid  (tlb_valid)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_we = 1'b0;
  logic [19:0] root_frame = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done_flag = 0;

  // bench model of the cache
  logic [19:0] m_root;
  logic [19:0] m_vpn [4];
  bit          m_v   [4];
  int          m_ptr;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return {h[31:12], 11'd0, (h[6:4] != 3'd0)};
  endfunction

  function automatic logic [31:0] outer_at(logic [19:0] root, logic [31:0] va);
    return root * 32'd4096 + (va / 32'h0040_0000) * 32'd4;
  endfunction

  function automatic logic [31:0] inner_at(logic [31:0] pte, logic [31:0] va);
    return (pte / 32'd4096) * 32'd4096 + ((va / 32'd4096) % 32'd1024) * 32'd4;
  endfunction

  // level of first invalid entry: 0 = none, 1 = outer, 2 = inner
  function automatic int bad_level(logic [19:0] root, logic [31:0] va);
    logic [31:0] p1;
    p1 = mem_word(outer_at(root, va));
    if (!p1[0]) return 1;
    if (!mem_word(inner_at(p1, va)) [0]) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] find_va(logic [19:0] start_vpn, int want);
    for (int i = 0; i < 100000; i++) begin
      logic [31:0] va;
      va = {start_vpn + 20'(i * 1031), 12'h5A4};
      if (bad_level(m_root, va) == want) return va;
    end
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_flush();
    for (int i = 0; i < 4; i++) m_v[i] = 0;
  endtask

  task automatic set_root(logic [19:0] r);
    @(negedge clk);
    root_we = 1'b1;
    root_frame = r;
    @(negedge clk);
    root_we = 1'b0;
    m_root = r;
    model_flush();
  endtask

  task automatic xlate(logic [31:0] va, bit mid_flush, logic [19:0] new_root, string tag);
    logic [31:0] a1, a2, p1, p2, exp_pa;
    bit exp_fault, hit, flushed, got;
    int exp_reads, reads, waitl, guard;
    a1 = outer_at(m_root, va);
    p1 = mem_word(a1);
    a2 = inner_at(p1, va);
    p2 = mem_word(a2);
    if (!p1[0]) begin exp_fault = 1; exp_reads = 1; end
    else begin exp_fault = !p2[0]; exp_reads = 2; end
    exp_pa = exp_fault ? 32'd0 : (p2 / 32'd4096) * 32'd4096 + (va % 32'd4096);
    hit = 0;
    for (int i = 0; i < 4; i++) if (m_v[i] && m_vpn[i] == va[31:12]) hit = 1;
    if (hit) exp_reads = 0;

    @(negedge clk);
    check({tag, " R8 ready idle"}, {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    reads = 0; flushed = 0; got = 0; guard = 0;
    waitl = $urandom % 4;
    while (!got) begin
      mem_ack = 1'b0;
      root_we = 1'b0;
      if (rsp_valid) begin
        got = 1;
        check({tag, " R4 fault"}, {31'd0, rsp_fault}, {31'd0, exp_fault});
        check({tag, " R3 paddr"}, rsp_paddr, exp_pa);
        check({tag, hit ? " R5 reads" : " R6 reads"}, reads, exp_reads);
      end else if (mem_req) begin
        if (req_ready) check({tag, " R8 busy"}, {31'd0, req_ready}, 32'd0);
        if (waitl == 0) begin
          check({tag, reads == 0 ? " R1 outer addr" : " R2 inner addr"},
                mem_addr, reads == 0 ? a1 : a2);
          mem_rdata = mem_word(mem_addr);
          mem_ack = 1'b1;
          reads++;
          waitl = $urandom % 4;
          if (mid_flush && reads == 1) begin
            root_we = 1'b1;
            root_frame = new_root;
            flushed = 1;
          end
        end else begin
          check({tag, " R9 hold"}, mem_addr, reads == 0 ? a1 : a2);
          waitl--;
        end
      end
      guard++;
      if (guard > 64) begin
        got = 1;
        check({tag, " R8 no response"}, 32'd0, 32'd1);
      end
      if (!got) @(negedge clk);
    end
    @(negedge clk);
    check({tag, " R8 pulse"}, {31'd0, rsp_valid}, 32'd0);
    if (flushed) begin
      m_root = new_root;
      model_flush();   // R11: nothing from this walk is kept
    end else if (!hit && !exp_fault) begin
      m_vpn[m_ptr] = va[31:12];
      m_v[m_ptr] = 1;
      m_ptr = (m_ptr + 1) % 4;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      done_flag = 1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] va_a, va_f;
    logic [31:0] pv [5];
    logic [19:0] pool [24];
    void'($urandom(32'd20240611));
    m_root = '0; m_ptr = 0;
    model_flush();
    repeat (3) @(negedge clk);
    check("R12 ready", {31'd0, req_ready}, 32'd1);
    check("R12 rsp", {31'd0, rsp_valid}, 32'd0);
    check("R12 mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;

    set_root(20'h12345);
    va_a = find_va(20'h00400, 0);
    xlate(va_a, 0, 0, "walk R1 R2 R3");
    xlate(va_a, 0, 0, "hit R5");
    va_f = find_va(20'h12000, 1);
    xlate(va_f, 0, 0, "outer fault R4");
    xlate(va_f, 0, 0, "refault R10");
    va_f = find_va(20'h33000, 2);
    xlate(va_f, 0, 0, "inner fault R4");
    xlate(va_f, 0, 0, "inner refault R10");

    pv[0] = find_va(20'h40000, 0);
    for (int i = 1; i < 5; i++) pv[i] = find_va(pv[i-1][31:12] + 20'd1, 0);
    for (int i = 0; i < 5; i++) xlate(pv[i], 0, 0, "rr fill R6");
    xlate(pv[1], 0, 0, "rr kept R6");
    xlate(pv[0], 0, 0, "rr evicted R6");

    set_root(20'h12345);
    xlate(pv[2], 0, 0, "after flush R7");
    xlate(pv[2], 0, 0, "refill R7");

    va_a = find_va(20'h50000, 0);
    xlate(va_a, 1, 20'h0ABCD, "mid flush R11");
    xlate(va_a, 0, 0, "after mid flush R11");

    for (int i = 0; i < 24; i++) pool[i] = 20'($urandom);
    for (int n = 0; n < 500; n++) begin
      int r;
      r = $urandom % 40;
      if (r == 0) set_root(20'($urandom));
      xlate({pool[$urandom % 24], 12'($urandom)}, (r == 1), 20'($urandom), "random");
    end

    done_flag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule